// File: doc/BRIEF.md
# Load/Store Lane Alignment Unit

This block sits between an integer core's execute stage and a 32-bit data memory port. For each access it adds the base register to the sign-extended 12-bit offset from the instruction word. Loads take the offset from instruction bits [31:20]. Stores take it from the split field, with bits [31:25] above bits [11:7]. The access width comes from the funct3 field, bits [14:12]. The block does not decode the opcode: the core says whether the access is a store.

For a store, the unit drives byte enables and lane-aligned write data. For a load, it drives the same size-and-offset byte enables. The memory answers one cycle later with the whole word. The unit keeps the size, signedness and lane offset of the load, selects the addressed byte or halfword from the returned word, and sign- or zero-extends it.

Reserved funct3 codes raise an illegal flag. Halfword or word accesses off their natural boundary raise a misaligned flag. In both cases no memory request is made, so nothing is written.

Top module: `lsu_lane_align`

## Requirements
- R1: `mem_addr` equals `op_base` plus the offset sign-extended from its bit 11, modulo 2^32. The offset is `op_inst[31:20]` for a load and `{op_inst[31:25], op_inst[11:7]}` for a store.
- R2: The width code is funct3 = `op_inst[14:12]`. Its low two bits select byte (00), halfword (01) or word (10). On an accepted access, `mem_be` is 4'b0001 for a byte, 4'b0011 for a halfword or 4'b1111 for a word, shifted left by `mem_addr[1:0]`. When `mem_req` is low, `mem_be` is 0.
- R3: On an accepted store, `mem_wdata` carries `op_src[7:0]` in all four lanes for a byte store (000), `op_src[15:0]` in both halves for a halfword store (001), and `op_src` unchanged for a word store (010).
- R4: Load codes are 000 (signed byte), 001 (signed halfword), 010 (word), 100 (unsigned byte) and 101 (unsigned halfword). A byte comes from lane `mem_addr[1:0]` of `mem_rdata`, bits 8*off+7..8*off. A halfword comes from bits 16*addr[1]+15..16*addr[1]. Codes 000 and 001 copy the top bit of the selected value into the upper bits; codes 100 and 101 fill them with zeros.
- R5: `ld_valid` is high exactly in the cycle after an accepted load (`mem_req`=1, `mem_we`=0), and low in every other cycle. While it is high, `ld_data` is taken from `mem_rdata` of that same cycle.
- R6: With `op_valid` high, `acc_illegal` is high for a load funct3 of 011, 110 or 111 and for a store funct3 of 011 through 111. In that case `mem_req` and `mem_we` stay low and no load response follows.
- R7: With `op_valid` high on a legal code, `acc_misaligned` is high for a halfword at an odd address or a word whose `mem_addr[1:0]` is not 00. In that case `mem_req` stays low, so memory is left unchanged. Byte accesses are never misaligned, and an illegal access never raises `acc_misaligned`.
- R8: With `op_valid` low, `mem_req`, `mem_we`, `mem_be`, `acc_illegal` and `acc_misaligned` are all 0, whatever the other inputs are.
- R9: While `rst_n` is low, and after it is released with no load issued, `ld_valid` is 0.
- R10: `mem_we` is high only for an accepted store. An accepted load has `mem_req`=1 and `mem_we`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An access is presented this cycle |
| op_is_store | input | 1 | 1 for a store, 0 for a load |
| op_inst | input | 32 | Instruction word (offset fields and funct3) |
| op_base | input | 32 (ADDR_W) | Base register value |
| op_src | input | 32 (DATA_W) | Store source register value |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 (ADDR_W) | Effective byte address |
| mem_be | output | 4 (DATA_W/8) | Byte lane enables |
| mem_wdata | output | 32 (DATA_W) | Lane-aligned write data |
| mem_rdata | input | 32 (DATA_W) | Read word, returned one cycle after a load request |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 (DATA_W) | Extended load result |
| acc_illegal | output | 1 | Reserved width code |
| acc_misaligned | output | 1 | Halfword or word off its natural boundary |

## Verification
The bench writes a known word through the unit. It then reads every byte lane and both halfword lanes back with signed and unsigned codes, using values whose top bit is set. If a lane is selected wrongly, neighbouring bytes appear in the result. If the extension is swapped, 0x80 comes back as 0x00000080 where 0xFFFFFF80 is expected.

Stores use negative split offsets and offsets with bits above bit 4 set. If the two offset pieces are joined in the wrong order, or the offset is not sign-extended, the address is wrong. Sub-word stores are followed by a word read, which exposes enables shifted into the wrong lane through corrupted neighbours.

Misaligned and reserved-code stores are followed by a read of the target word. A design that still wrote memory, or flagged a byte access as misaligned, shows up there.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  typedef struct packed {
    logic      legal;
    logic      zext;
    acc_size_e size;
  } acc_kind_t;

  // Width, signedness and legality from the funct3 code.
  function automatic acc_kind_t decode_kind(input logic is_store, input logic [2:0] f3);
    acc_kind_t k;
    k.legal = 1'b1;
    k.zext  = f3[2];
    k.size  = SZ_BYTE;
    case (f3[1:0])
      2'b00:   k.size = SZ_BYTE;
      2'b01:   k.size = SZ_HALF;
      2'b10:   k.size = SZ_WORD;
      default: k.legal = 1'b0;
    endcase
    // Unsigned variants exist only for loads narrower than a word.
    if (f3[2] && (is_store || f3[1])) k.legal = 1'b0;
    return k;
  endfunction

endpackage

// File: rtl/lsu_agen.sv
module lsu_agen #(
  parameter int ADDR_W = 32
) (
  input  logic              is_store,
  input  logic [6:0]        imm_hi,
  input  logic [4:0]        imm_lo_ld,
  input  logic [4:0]        imm_lo_st,
  input  logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] addr
);
  localparam int IMM_W = 12;
  localparam int PAD_W = ADDR_W - IMM_W;

  logic [IMM_W-1:0] imm;

  // The upper seven bits share one position in both formats; only the low
  // five bits move between the load and store encodings.
  assign imm  = {imm_hi, (is_store ? imm_lo_st : imm_lo_ld)};
  assign addr = base + {{PAD_W{imm[IMM_W-1]}}, imm};
endmodule

// File: rtl/lsu_store_lane.sv
module lsu_store_lane
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  acc_size_e                               size,
  input  logic [$clog2(DATA_W/8)-1:0]             off,
  input  logic [DATA_W-1:0]                       src,
  output logic [DATA_W/8-1:0]                     be,
  output logic [DATA_W-1:0]                       wdata
);
  localparam int LANES = DATA_W / 8;

  logic [LANES-1:0] mask;

  always_comb begin
    case (size)
      SZ_BYTE: mask = LANES'(1);
      SZ_HALF: mask = LANES'(3);
      default: mask = '1;
    endcase
  end

  assign be = mask << off;

  // Replicate the narrow value into every lane; the enables pick the lane.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign wdata[8*g +: 8] = (size == SZ_BYTE) ? src[7:0] :
                             (size == SZ_HALF) ? src[8*(g%2) +: 8] :
                                                 src[8*g +: 8];
  end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  acc_size_e                   size,
  input  logic                        zext,
  input  logic [$clog2(DATA_W/8)-1:0] off,
  input  logic [DATA_W-1:0]           rdata,
  output logic [DATA_W-1:0]           data
);
  logic [DATA_W-1:0] shifted;
  logic              unused_shift_hi;

  // Bring the addressed lane down to bit 0.
  assign shifted         = rdata >> {off, 3'b000};
  assign unused_shift_hi = ^shifted[DATA_W-1:16];

  always_comb begin
    case (size)
      SZ_BYTE: data = {{(DATA_W-8){~zext & shifted[7]}}, shifted[7:0]};
      SZ_HALF: data = {{(DATA_W-16){~zext & shifted[15]}}, shifted[15:0]};
      default: data = rdata;
    endcase
  end
endmodule

// File: rtl/lsu_lane_align.sv
module lsu_lane_align
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                op_valid,
  input  logic                op_is_store,
  input  logic [31:0]         op_inst,
  input  logic [ADDR_W-1:0]   op_base,
  input  logic [DATA_W-1:0]   op_src,
  output logic                mem_req,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W/8-1:0] mem_be,
  output logic [DATA_W-1:0]   mem_wdata,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic                ld_valid,
  output logic [DATA_W-1:0]   ld_data,
  output logic                acc_illegal,
  output logic                acc_misaligned
);
  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);

  acc_kind_t        kind;
  logic [OFF_W-1:0] off;
  logic             mis_raw;
  logic             accept;
  logic [LANES-1:0] be_raw;
  logic             unused_inst_bits;

  // Load response tag: registered state and next state
  logic             rsp_vld_q, rsp_vld_d;
  acc_size_e        rsp_size_q, rsp_size_d;
  logic             rsp_zext_q, rsp_zext_d;
  logic [OFF_W-1:0] rsp_off_q, rsp_off_d;
  logic             rsp_cap;

  assign kind             = decode_kind(op_is_store, op_inst[14:12]);
  assign unused_inst_bits = ^{op_inst[19:15], op_inst[6:0]};

  lsu_agen #(.ADDR_W(ADDR_W)) u_agen (
    .is_store  (op_is_store),
    .imm_hi    (op_inst[31:25]),
    .imm_lo_ld (op_inst[24:20]),
    .imm_lo_st (op_inst[11:7]),
    .base      (op_base),
    .addr      (mem_addr)
  );

  assign off = mem_addr[OFF_W-1:0];

  always_comb begin
    case (kind.size)
      SZ_HALF: mis_raw = off[0];
      SZ_WORD: mis_raw = |off;
      default: mis_raw = 1'b0;
    endcase
  end

  assign acc_illegal    = op_valid & ~kind.legal;
  assign acc_misaligned = op_valid & kind.legal & mis_raw;
  assign accept         = op_valid & kind.legal & ~mis_raw;
  assign mem_req        = accept;
  assign mem_we         = accept & op_is_store;

  lsu_store_lane #(.DATA_W(DATA_W)) u_store (
    .size  (kind.size),
    .off   (off),
    .src   (op_src),
    .be    (be_raw),
    .wdata (mem_wdata)
  );

  assign mem_be = accept ? be_raw : '0;

  // Next state of the response tag
  assign rsp_cap = accept & ~op_is_store;

  always_comb begin
    rsp_vld_d  = rsp_cap;
    rsp_size_d = rsp_size_q;
    rsp_zext_d = rsp_zext_q;
    rsp_off_d  = rsp_off_q;
    if (rsp_cap) begin
      rsp_size_d = kind.size;
      rsp_zext_d = kind.zext;
      rsp_off_d  = off;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_vld_q  <= 1'b0;
      rsp_size_q <= SZ_BYTE;
      rsp_zext_q <= 1'b0;
      rsp_off_q  <= '0;
    end else begin
      rsp_vld_q  <= rsp_vld_d;
      rsp_size_q <= rsp_size_d;
      rsp_zext_q <= rsp_zext_d;
      rsp_off_q  <= rsp_off_d;
    end
  end

  lsu_load_extract #(.DATA_W(DATA_W)) u_load (
    .size  (rsp_size_q),
    .zext  (rsp_zext_q),
    .off   (rsp_off_q),
    .rdata (mem_rdata),
    .data  (ld_data)
  );

  assign ld_valid = rsp_vld_q;
endmodule

// File: rtl/lsu_lane_align_chk.sv
module lsu_lane_align_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_valid,
  input logic             op_is_store,
  input logic [2:0]       op_f3,
  input logic             mem_req,
  input logic             mem_we,
  input logic [1:0]       addr_lo,
  input logic [LANES-1:0] mem_be,
  input logic             ld_valid,
  input logic             acc_illegal,
  input logic             acc_misaligned
);
  AST_WE_NEEDS_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_req && op_is_store)) else $error("write without store request"); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |-> (!mem_req && !acc_illegal && !acc_misaligned)) else $error("activity while idle"); // R8

  AST_BAD_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_illegal || acc_misaligned) |-> !mem_req) else $error("flagged access reached memory"); // R6

  AST_ILLEGAL_NOT_MIS: assert property (@(posedge clk) disable iff (!rst_n)
    acc_illegal |-> !acc_misaligned) else $error("both flags raised"); // R7

  AST_MIS_HALF_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !acc_illegal && op_f3[1:0] == 2'b01 && addr_lo[0]) |-> acc_misaligned)
    else $error("odd halfword not flagged"); // R7

  AST_LOAD_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |=> ld_valid) else $error("load response missing"); // R5

  AST_NO_STRAY_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && !mem_we) |=> !ld_valid) else $error("spurious load response"); // R5

  AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && op_f3[1:0] == 2'b00) |-> ($countones(mem_be) == 1)) else $error("byte enable count"); // R2

  AST_WORD_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && op_f3[1:0] == 2'b10) |-> (&mem_be)) else $error("word enable pattern"); // R2

  AST_BE_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_req |-> (mem_be == '0)) else $error("enables without request"); // R2
endmodule

bind lsu_lane_align lsu_lane_align_chk #(.LANES(DATA_W/8)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .op_valid       (op_valid),
  .op_is_store    (op_is_store),
  .op_f3          (op_inst[14:12]),
  .mem_req        (mem_req),
  .mem_we         (mem_we),
  .addr_lo        (mem_addr[1:0]),
  .mem_be         (mem_be),
  .ld_valid       (ld_valid),
  .acc_illegal    (acc_illegal),
  .acc_misaligned (acc_misaligned)
);

// File: tb/sim_lsu_lane_align.sv
module sim_lsu_lane_align;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_WORDS  = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic        op_is_store;
  logic [31:0] op_inst;
  logic [31:0] op_base;
  logic [31:0] op_src;
  logic        mem_req;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;
  logic        ld_valid;
  logic [31:0] ld_data;
  logic        acc_illegal;
  logic        acc_misaligned;

  logic [31:0] mem_model [MEM_WORDS];
  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lsu_lane_align u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_is_store(op_is_store),
    .op_inst(op_inst), .op_base(op_base), .op_src(op_src),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .ld_valid(ld_valid),
    .ld_data(ld_data), .acc_illegal(acc_illegal), .acc_misaligned(acc_misaligned)
  );

  // Memory model: byte-enabled writes, read word registered one cycle later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_WORDS; i++)
        mem_model[i] <= 32'h1357_9BDF ^ (32'h1111_1111 * 32'(i));
      mem_rdata <= '0;
    end else if (mem_req) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem_model[mem_addr[5:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
      end else begin
        mem_rdata <= mem_model[mem_addr[5:2]];
      end
    end
  end

  function automatic logic [31:0] f_addr(input logic [31:0] b, input logic [11:0] imm);
    return b + {{20{imm[11]}}, imm};
  endfunction

  function automatic logic f_legal(input logic st, input logic [2:0] f3);
    if (st) return (f3 == 3'd0 || f3 == 3'd1 || f3 == 3'd2);
    return (f3 == 3'd0 || f3 == 3'd1 || f3 == 3'd2 || f3 == 3'd4 || f3 == 3'd5);
  endfunction

  function automatic logic f_mis(input logic [2:0] f3, input logic [31:0] a);
    case (f3[1:0])
      2'b01:   return a[0];
      2'b10:   return (a[1:0] != 2'b00);
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [3:0] f_be(input logic [2:0] f3, input logic [31:0] a);
    case (f3[1:0])
      2'b00:   return 4'b0001 << a[1:0];
      2'b01:   return 4'b0011 << a[1:0];
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [31:0] f_wdata(input logic [2:0] f3, input logic [31:0] s);
    case (f3[1:0])
      2'b00:   return {4{s[7:0]}};
      2'b01:   return {2{s[15:0]}};
      default: return s;
    endcase
  endfunction

  function automatic logic [31:0] f_load(input logic [2:0] f3, input logic [31:0] a, input logic [31:0] w);
    logic [31:0] sh;
    sh = w >> (8 * a[1:0]);
    case (f3)
      3'b000:  return {{24{sh[7]}}, sh[7:0]};
      3'b100:  return {24'h0, sh[7:0]};
      3'b001:  return {{16{sh[15]}}, sh[15:0]};
      3'b101:  return {16'h0, sh[15:0]};
      default: return w;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_op(input logic st, input logic [2:0] f3, input logic [11:0] imm,
                       input logic [31:0] base, input logic [31:0] src);
    logic [31:0] a, inst, exp_ld;
    logic leg, mis, acc;
    a   = f_addr(base, imm);
    leg = f_legal(st, f3);
    mis = leg && f_mis(f3, a);
    acc = leg && !mis;
    if (st) inst = {imm[11:5], 5'($urandom), 5'($urandom), f3, imm[4:0], 7'b0100011};
    else    inst = {imm, 5'($urandom), f3, 5'($urandom), 7'b0000011};
    @(negedge clk);
    op_valid = 1'b1; op_is_store = st; op_inst = inst; op_base = base; op_src = src;
    #1;
    chk("R5 idle before issue", 32'(ld_valid), 32'd0);
    chk("R1 address", mem_addr, a);
    chk("R6 illegal flag", 32'(acc_illegal), 32'(!leg));
    chk("R7 misaligned flag", 32'(acc_misaligned), 32'(mis));
    chk("R6 R7 request", 32'(mem_req), 32'(acc));
    chk("R10 write enable", 32'(mem_we), 32'(acc && st));
    chk("R2 byte enables", 32'(mem_be), acc ? 32'(f_be(f3, a)) : 32'd0);
    if (acc && st) chk("R3 write data", mem_wdata, f_wdata(f3, src));
    exp_ld = f_load(f3, a, mem_model[a[5:2]]);
    @(negedge clk);
    op_valid = 1'b0;
    #1;
    chk("R5 load valid", 32'(ld_valid), 32'(acc && !st));
    if (acc && !st) chk("R4 load data", ld_data, exp_ld);
  endtask

  task automatic do_idle();
    @(negedge clk);
    op_valid = 1'b0; op_is_store = 1'b1; op_inst = $urandom; op_base = $urandom; op_src = $urandom;
    #1;
    chk("R8 idle request", 32'(mem_req), 32'd0);
    chk("R8 idle write", 32'(mem_we), 32'd0);
    chk("R8 idle enables", 32'(mem_be), 32'd0);
    chk("R8 idle flags", 32'({acc_illegal, acc_misaligned}), 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R5 watchdog act=hung exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7331));
    rst_n = 1'b0; op_valid = 1'b0; op_is_store = 1'b0;
    op_inst = '0; op_base = '0; op_src = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R9 ld_valid in reset", 32'(ld_valid), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R9 ld_valid after reset", 32'(ld_valid), 32'd0);
    chk("R8 request after reset", 32'(mem_req), 32'd0);

    // Word store, then every lane read back signed and unsigned (R4)
    do_op(1'b1, 3'b010, 12'h000, 32'h10, 32'h8765_F0A5);
    for (int k = 0; k < 4; k++) begin
      do_op(1'b0, 3'b000, 12'(k), 32'h10, 32'h0);
      do_op(1'b0, 3'b100, 12'(k), 32'h10, 32'h0);
    end
    do_op(1'b0, 3'b001, 12'h000, 32'h10, 32'h0);
    do_op(1'b0, 3'b001, 12'h002, 32'h10, 32'h0);
    do_op(1'b0, 3'b101, 12'h002, 32'h10, 32'h0);
    do_op(1'b0, 3'b010, 12'h000, 32'h10, 32'h0);

    // Negative split offset store, halfword store, merged word read (R1 R2 R3)
    do_op(1'b1, 3'b000, 12'hFF1, 32'h30, 32'hDEAD_00C3);
    do_op(1'b1, 3'b001, 12'h002, 32'h20, 32'h1234_BEEF);
    do_op(1'b0, 3'b010, 12'h000, 32'h20, 32'h0);
    do_op(1'b1, 3'b000, 12'h7E5, 32'h100, 32'h0000_005A);
    do_op(1'b0, 3'b100, 12'h8E5, 32'h800, 32'h0);
    do_op(1'b0, 3'b010, 12'hFFC, 32'h0, 32'h0);

    // Reserved codes (R6)
    do_op(1'b0, 3'b011, 12'h000, 32'h10, 32'h0);
    do_op(1'b0, 3'b110, 12'h000, 32'h10, 32'h0);
    do_op(1'b0, 3'b111, 12'h000, 32'h10, 32'h0);
    for (int f = 3; f < 8; f++) do_op(1'b1, 3'(f), 12'h000, 32'h10, 32'hFFFF_FFFF);

    // Misaligned accesses leave memory untouched; a byte at lane 3 is fine (R7)
    do_op(1'b0, 3'b001, 12'h001, 32'h10, 32'h0);
    do_op(1'b0, 3'b101, 12'h003, 32'h10, 32'h0);
    do_op(1'b0, 3'b010, 12'h002, 32'h10, 32'h0);
    do_op(1'b1, 3'b001, 12'h001, 32'h10, 32'h0000_0000);
    do_op(1'b1, 3'b010, 12'h003, 32'h10, 32'h0000_0000);
    do_op(1'b0, 3'b010, 12'h000, 32'h10, 32'h0);
    do_op(1'b1, 3'b000, 12'h003, 32'h10, 32'h0000_0011);
    do_op(1'b0, 3'b010, 12'h000, 32'h10, 32'h0);

    // Idle cycles with noisy inputs (R8)
    repeat (3) do_idle();

    // Constrained random mix (R1 to R10)
    for (int n = 0; n < 400; n++) begin
      logic [31:0] base;
      base = ($urandom_range(3, 0) == 0) ? $urandom : 32'($urandom_range(255, 0));
      do_op(1'($urandom), 3'($urandom_range(7, 0)), 12'($urandom), base, $urandom);
      if ($urandom_range(9, 0) == 0) do_idle();
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule